// File: doc/BRIEF.md
# Dual-Comparator Bus Trigger Unit

This block watches a processor bus on every clock and decides, from two programmable comparators, when a trace recorder should fire and which bus cycles it should keep. Comparator A and comparator B each hold a reference address and a reference data byte. Each comparator can also require a particular access direction (read or write) and an exact data value. A mode field selects one of nine ways of combining the two comparators: a plain match, an either-or match, a two-step sequence, same-cycle data equal or data unequal tests, an inclusive address window or its complement, and two qualification modes that keep only the cycles that hit B.

Software loads the reference values and the control word through a small write-only register port. Writing the control word arms the unit and restarts the A-then-B sequence. The unit then produces exactly one trigger pulse for the first qualifying bus cycle and stays quiet until the control word is written again. A store-enable output runs alongside the trigger on every cycle and tells an attached trace buffer whether to capture that bus cycle. Both outputs are registered and appear one clock after the bus cycle they describe.

Top module: `bus_trigger_unit`

## Requirements
- R1: After reset both outputs are low, the unit is disarmed, the A-then-B sequence flag is clear, and every reference register and control field reads as zero, which selects mode 0 with no direction or data qualifiers.
- R2: A write with `cfg_sel` 0, 1, 2 or 3 loads the A address, A data, B address or B data respectively, and 4 loads the control word. The control word holds the mode in bits 3:0, the A direction enable in bit 4, the A direction value in bit 5 (1 = read), the A data enable in bit 6, the B direction enable in bit 7, the B direction value in bit 8, and the B data enable in bit 9. Selects 5 to 7 have no effect. A new value governs bus cycles from the next clock on. A control write arms the unit, clears the sequence flag, and forces both outputs low for the bus cycle that shares its clock.
- R3: A comparator matches a bus cycle when `bus_valid` is high, the address equals its reference address, the direction equals its direction value if its direction enable is set, and the data equals its reference data if its data enable is set.
- R4: Mode 0 triggers on a comparator A match.
- R5: Mode 1 triggers when comparator A or comparator B matches.
- R6: Mode 2 triggers on a comparator B match only when comparator A matched in some earlier cycle since the last control write. An A match sets a sticky flag that only a control write clears. An A match and a B match in the same cycle do not trigger unless the flag was already set.
- R7: Mode 3 triggers when comparator A matches and, in the same cycle, the data equals the B data and the B direction qualifier is met. Mode 4 triggers when comparator A matches, the B direction qualifier is met, and the data differs from the B data. In both modes the B data enable is ignored.
- R8: Mode 5 triggers on a valid cycle whose address lies between the A address (lower bound) and the B address (upper bound), both inclusive. Mode 6 triggers on a valid cycle whose address lies outside that span.
- R9: Mode 7 raises store-enable on every comparator B match and triggers on it. Mode 8 does the same only for B matches after the sequence flag of R6 is set.
- R10: In modes 0 to 6 store-enable is high for every valid bus cycle. In modes 9 to 15 neither output is ever raised.
- R11: The trigger is a single-cycle pulse, produced only while armed. The first triggering cycle disarms the unit, so later qualifying cycles give no pulse until the next control write.
- R12: Both outputs are registered and reflect the bus cycle sampled on the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data |
| bus_rd | input | 1 | Access direction, 1 = read, 0 = write |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data (ADDR_W must be at least 10) |
| trig_o | output | 1 | One-cycle trigger pulse |
| store_o | output | 1 | Trace capture qualifier for the previous bus cycle |

## Verification
Each result is due exactly one clock after the bus cycle that causes it. Configuration writes reach the comparators one clock after the write, so their effect appears on the outputs two clocks after the write. The bench drives each bus cycle on a falling edge and advances a behavioural model at the following rising edge. It then compares both outputs with the model at the next falling edge, so every comparison is made one register stage after the stimulus. The directed sequences place matches on the range bounds, before and after the A event of the sequence modes, and in the same clock as a control write. A randomised run then mixes the modes with addresses drawn close to the two references.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [3:0] {
    M_A_ONLY        = 4'd0,
    M_A_OR_B        = 4'd1,
    M_A_THEN_B      = 4'd2,
    M_A_AND_BDATA   = 4'd3,
    M_A_AND_NBDATA  = 4'd4,
    M_IN_RANGE      = 4'd5,
    M_OUT_RANGE     = 4'd6,
    M_REC_B         = 4'd7,
    M_A_THEN_REC_B  = 4'd8
  } trig_mode_e;

  localparam int MODE_W   = 4;
  localparam int SEL_W    = 3;
  localparam int CTRL_W   = 10;

  localparam logic [SEL_W-1:0] SEL_A_ADDR = 3'd0;
  localparam logic [SEL_W-1:0] SEL_A_DATA = 3'd1;
  localparam logic [SEL_W-1:0] SEL_B_ADDR = 3'd2;
  localparam logic [SEL_W-1:0] SEL_B_DATA = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd4;

  localparam int BIT_A_RW_EN  = 4;
  localparam int BIT_A_RW_VAL = 5;
  localparam int BIT_A_DAT_EN = 6;
  localparam int BIT_B_RW_EN  = 7;
  localparam int BIT_B_RW_VAL = 8;
  localparam int BIT_B_DAT_EN = 9;

endpackage

// File: rtl/trig_comparator.sv
module trig_comparator #(
  parameter int ADDR_W = 16
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              rd,
  input  logic              rw_en,
  input  logic              rw_val,
  input  logic              dat_en,
  input  logic              data_eq,
  output logic              hit,
  output logic              rw_ok
);

  logic addr_eq;

  always_comb begin
    addr_eq = (addr == ref_addr);
    rw_ok   = !rw_en || (rd == rw_val);
    hit     = valid && addr_eq && rw_ok && (!dat_en || data_eq);
  end

endmodule

// File: rtl/trig_combiner.sv
module trig_combiner
  import trig_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic              seq_seen,
  input  logic              a_hit,
  input  logic              a_rw_ok,
  input  logic              b_hit,
  input  logic              b_rw_ok,
  input  logic              b_data_eq,
  output logic              hit,
  output logic              store
);

  logic in_span;

  always_comb begin
    in_span = (bus_addr >= lo_addr) && (bus_addr <= hi_addr);
    hit     = 1'b0;
    store   = bus_valid;
    case (mode)
      M_A_ONLY:       hit = a_hit;
      M_A_OR_B:       hit = a_hit || b_hit;
      M_A_THEN_B:     hit = seq_seen && b_hit;
      M_A_AND_BDATA:  hit = a_hit && b_rw_ok && b_data_eq;
      M_A_AND_NBDATA: hit = a_hit && b_rw_ok && !b_data_eq;
      M_IN_RANGE:     hit = bus_valid && in_span;
      M_OUT_RANGE:    hit = bus_valid && !in_span;
      M_REC_B: begin
        hit   = b_hit;
        store = b_hit;
      end
      M_A_THEN_REC_B: begin
        hit   = seq_seen && b_hit;
        store = seq_seen && b_hit;
      end
      default: begin
        hit   = 1'b0;
        store = 1'b0;
      end
    endcase
  end

  // R3: a comparator hit always carries a satisfied direction qualifier
  always_comb begin
    a_r3_hit_has_rw : assert (!a_hit || a_rw_ok);
  end

  // R10: reserved modes raise nothing
  always_comb begin
    a_r10_reserved_quiet : assert (!(mode > MODE_W'(M_A_THEN_REC_B)) || (!hit && !store));
  end

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
  import trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [MODE_W-1:0] mode,
  input  logic              a_hit,
  input  logic              hit,
  input  logic              store,
  output logic              seq_seen,
  output logic              trig_o,
  output logic              store_o
);

  logic armed_q, armed_d;
  logic seq_q, seq_d;
  logic trig_q, trig_d;
  logic store_q, store_d;

  always_comb begin
    armed_d = armed_q;
    seq_d   = seq_q;
    trig_d  = 1'b0;
    store_d = 1'b0;
    if (ctrl_wr) begin
      armed_d = 1'b1;
      seq_d   = 1'b0;
    end else begin
      trig_d  = armed_q && hit;
      store_d = store;
      if (armed_q && hit) armed_d = 1'b0;
      if (a_hit)          seq_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seq_q   <= 1'b0;
      trig_q  <= 1'b0;
      store_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      seq_q   <= seq_d;
      trig_q  <= trig_d;
      store_q <= store_d;
    end
  end

  assign seq_seen = seq_q;
  assign trig_o   = trig_q;
  assign store_o  = store_q;

  // R11: trigger never lasts two cycles
  a_r11_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q);

  // R11: a pulse needs the unit to have been armed
  a_r11_needs_armed : assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> $past(armed_q));

  // R6: in the sequence mode a pulse needs an earlier A event
  a_r6_seq_order : assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && $past(mode) == MODE_W'(M_A_THEN_B)) |-> $past(seq_q));

  // R2: a control write silences both outputs for its cycle
  a_r2_ctrl_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (!trig_q && !store_q));

  // R2: a control write leaves the unit armed with a clear sequence
  a_r2_ctrl_arms : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (armed_q && !seq_q));

endmodule

// File: rtl/bus_trigger_unit.sv
module bus_trigger_unit
  import trig_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              trig_o,
  output logic              store_o
);

  logic [ADDR_W-1:0] a_addr_q, a_addr_d, b_addr_q, b_addr_d;
  logic [DATA_W-1:0] a_data_q, a_data_d, b_data_q, b_data_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_wr;

  // configuration next-state
  always_comb begin
    a_addr_d = a_addr_q;
    a_data_d = a_data_q;
    b_addr_d = b_addr_q;
    b_data_d = b_data_q;
    ctrl_d   = ctrl_q;
    ctrl_wr  = 1'b0;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_A_ADDR: a_addr_d = cfg_wdata;
        SEL_A_DATA: a_data_d = cfg_wdata[DATA_W-1:0];
        SEL_B_ADDR: b_addr_d = cfg_wdata;
        SEL_B_DATA: b_data_d = cfg_wdata[DATA_W-1:0];
        SEL_CTRL: begin
          ctrl_d  = cfg_wdata[CTRL_W-1:0];
          ctrl_wr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_addr_q <= '0;
      a_data_q <= '0;
      b_addr_q <= '0;
      b_data_q <= '0;
      ctrl_q   <= '0;
    end else if (cfg_we) begin
      a_addr_q <= a_addr_d;
      a_data_q <= a_data_d;
      b_addr_q <= b_addr_d;
      b_data_q <= b_data_d;
      ctrl_q   <= ctrl_d;
    end
  end

  logic a_data_eq, b_data_eq;
  logic a_hit, a_rw_ok, b_hit, b_rw_ok;
  logic hit, store, seq_seen;

  assign a_data_eq = (bus_data == a_data_q);
  assign b_data_eq = (bus_data == b_data_q);

  trig_comparator #(.ADDR_W(ADDR_W)) u_cmp_a (
    .valid   (bus_valid),
    .addr    (bus_addr),
    .ref_addr(a_addr_q),
    .rd      (bus_rd),
    .rw_en   (ctrl_q[BIT_A_RW_EN]),
    .rw_val  (ctrl_q[BIT_A_RW_VAL]),
    .dat_en  (ctrl_q[BIT_A_DAT_EN]),
    .data_eq (a_data_eq),
    .hit     (a_hit),
    .rw_ok   (a_rw_ok)
  );

  trig_comparator #(.ADDR_W(ADDR_W)) u_cmp_b (
    .valid   (bus_valid),
    .addr    (bus_addr),
    .ref_addr(b_addr_q),
    .rd      (bus_rd),
    .rw_en   (ctrl_q[BIT_B_RW_EN]),
    .rw_val  (ctrl_q[BIT_B_RW_VAL]),
    .dat_en  (ctrl_q[BIT_B_DAT_EN]),
    .data_eq (b_data_eq),
    .hit     (b_hit),
    .rw_ok   (b_rw_ok)
  );

  trig_combiner #(.ADDR_W(ADDR_W)) u_comb (
    .mode     (ctrl_q[MODE_W-1:0]),
    .bus_valid(bus_valid),
    .bus_addr (bus_addr),
    .lo_addr  (a_addr_q),
    .hi_addr  (b_addr_q),
    .seq_seen (seq_seen),
    .a_hit    (a_hit),
    .a_rw_ok  (a_rw_ok),
    .b_hit    (b_hit),
    .b_rw_ok  (b_rw_ok),
    .b_data_eq(b_data_eq),
    .hit      (hit),
    .store    (store)
  );

  trig_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .mode    (ctrl_q[MODE_W-1:0]),
    .a_hit   (a_hit),
    .hit     (hit),
    .store   (store),
    .seq_seen(seq_seen),
    .trig_o  (trig_o),
    .store_o (store_o)
  );

  // R8: an inside-window pulse comes from an address within the bounds
  a_r8_window_bounds : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !cfg_we && ctrl_q[MODE_W-1:0] == MODE_W'(M_IN_RANGE) && hit)
      |-> (bus_addr >= a_addr_q && bus_addr <= b_addr_q));

  // R12: store output follows a valid bus cycle one clock later
  a_r12_store_latency : assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> $past(bus_valid));

endmodule

// File: tb/bus_trigger_unit_test.sv
module bus_trigger_unit_test;

  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic          bus_rd;
  logic          cfg_we;
  logic [2:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic          trig_o, store_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  bus_trigger_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_rd(bus_rd), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .trig_o(trig_o), .store_o(store_o)
  );

  // behavioural reference state
  logic [AW-1:0] m_aa, m_ba;
  logic [DW-1:0] m_ad, m_bd;
  logic [9:0]    m_ctl;
  bit            m_armed, m_seq;

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic r, input logic we, input logic [2:0] sel,
                      input logic [AW-1:0] wd, input string tag);
    bit am, bm, brw, bdq, inr, hit, st, ctl;
    int md;
    bus_valid = v; bus_addr = a; bus_data = d; bus_rd = r;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    md  = int'(m_ctl[3:0]);
    am  = v && (a == m_aa) && (!m_ctl[4] || r == m_ctl[5]) && (!m_ctl[6] || d == m_ad);
    brw = !m_ctl[7] || r == m_ctl[8];
    bdq = (d == m_bd);
    bm  = v && (a == m_ba) && brw && (!m_ctl[9] || bdq);
    inr = v && (a >= m_aa) && (a <= m_ba);
    st  = v;
    case (md)
      0: hit = am;
      1: hit = am || bm;
      2: hit = m_seq && bm;
      3: hit = am && brw && bdq;
      4: hit = am && brw && !bdq;
      5: hit = inr;
      6: hit = v && !inr;
      7: begin hit = bm; st = bm; end
      8: begin hit = m_seq && bm; st = m_seq && bm; end
      default: begin hit = 0; st = 0; end
    endcase
    ctl = we && (sel == 3'd4);
    @(posedge clk);
    begin
      bit et, es;
      et = !ctl && m_armed && hit;
      es = !ctl && st;
      if (ctl) begin m_armed = 1; m_seq = 0; end
      else begin
        if (et) m_armed = 0;
        if (am) m_seq = 1;
      end
      if (we) case (sel)
        3'd0: m_aa = wd;
        3'd1: m_ad = wd[DW-1:0];
        3'd2: m_ba = wd;
        3'd3: m_bd = wd[DW-1:0];
        3'd4: m_ctl = wd[9:0];
        default: ;
      endcase
      @(negedge clk);
      check({tag, "/R12"}, trig_o, et, "trig");
      check({tag, "/R12"}, store_o, es, "store");
    end
  endtask

  task automatic bus(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic r, input string tag);
    step(1'b1, a, d, r, 1'b0, 3'd0, '0, tag);
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [AW-1:0] wd, input string tag);
    step(1'b0, '0, '0, 1'b0, 1'b1, sel, wd, tag);
  endtask

  function automatic string mtag(input int md);
    case (md)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3, 4: return "R7";
      5, 6: return "R8";
      7, 8: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 0; bus_addr = '0; bus_data = '0; bus_rd = 0;
    cfg_we = 0; cfg_sel = '0; cfg_wdata = '0;
    m_aa = '0; m_ba = '0; m_ad = '0; m_bd = '0; m_ctl = '0; m_armed = 0; m_seq = 0;
    repeat (3) @(negedge clk);
    check("R1", trig_o, 1'b0, "trig in reset");
    check("R1", store_o, 1'b0, "store in reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zero references and disarmed: a match at address 0 gives no pulse
    bus(16'h0000, 8'h00, 0, "R1");
    step(1'b0, '0, '0, 0, 0, 3'd0, '0, "R1");

    // R2: load references
    cfg(3'd0, 16'h1000, "R2");
    cfg(3'd2, 16'h2000, "R2");
    cfg(3'd3, 16'h005A, "R2");
    cfg(3'd5, 16'hFFFF, "R2");      // unused select
    cfg(3'd4, 16'd0, "R2");
    // R4 and R11
    bus(16'h0FFF, 8'h00, 0, "R4");
    bus(16'h1000, 8'h00, 0, "R4");
    bus(16'h1000, 8'h00, 0, "R11");
    step(1'b0, 16'h1000, '0, 0, 0, 3'd0, '0, "R3");
    // R5
    cfg(3'd4, 16'd1, "R2");
    bus(16'h2000, 8'h00, 1, "R5");
    cfg(3'd4, 16'd1, "R2");
    bus(16'h1000, 8'h00, 1, "R5");
    // R6
    cfg(3'd4, 16'd2, "R2");
    bus(16'h2000, 8'h00, 0, "R6");
    bus(16'h1000, 8'h00, 0, "R6");
    bus(16'h1234, 8'h00, 0, "R6");
    bus(16'h2000, 8'h00, 0, "R6");
    // R2: control write in the same clock as an A hit
    step(1'b1, 16'h1000, '0, 0, 1'b1, 3'd4, 16'd0, "R2");
    bus(16'h1000, 8'h00, 0, "R2");
    // R7
    cfg(3'd4, 16'd3 | 16'h0080, "R2");
    bus(16'h1000, 8'h5A, 1, "R7");
    bus(16'h1000, 8'h11, 0, "R7");
    bus(16'h1000, 8'h5A, 0, "R7");
    cfg(3'd4, 16'd4 | 16'h0080, "R2");
    bus(16'h1000, 8'h5A, 0, "R7");
    bus(16'h1000, 8'h11, 0, "R7");
    // R8 inclusive bounds
    cfg(3'd4, 16'd5, "R2");
    bus(16'h0FFF, 8'h00, 0, "R8");
    bus(16'h1000, 8'h00, 0, "R8");
    cfg(3'd4, 16'd5, "R2");
    bus(16'h2001, 8'h00, 0, "R8");
    bus(16'h2000, 8'h00, 0, "R8");
    cfg(3'd4, 16'd6, "R2");
    bus(16'h1800, 8'h00, 0, "R8");
    bus(16'h2001, 8'h00, 0, "R8");
    cfg(3'd4, 16'd6, "R2");
    bus(16'h0FFF, 8'h00, 0, "R8");
    // R9
    cfg(3'd4, 16'd7 | 16'h0200, "R2");
    bus(16'h2000, 8'h5A, 0, "R9");
    bus(16'h2000, 8'h11, 0, "R9");
    bus(16'h2000, 8'h5A, 1, "R9");
    bus(16'h1000, 8'h5A, 0, "R9");
    cfg(3'd4, 16'd8, "R2");
    bus(16'h2000, 8'h00, 0, "R9");
    bus(16'h1000, 8'h00, 0, "R9");
    bus(16'h2000, 8'h00, 0, "R9");
    bus(16'h2000, 8'h00, 0, "R9");
    // R3: A direction and data qualifiers
    cfg(3'd1, 16'h0033, "R2");
    cfg(3'd4, 16'h0070, "R2");
    bus(16'h1000, 8'h33, 0, "R3");
    bus(16'h1000, 8'h34, 1, "R3");
    bus(16'h1000, 8'h33, 1, "R3");
    // R10: reserved modes
    cfg(3'd4, 16'd9, "R2");
    bus(16'h1000, 8'h33, 1, "R10");
    cfg(3'd4, 16'd15, "R2");
    bus(16'h2000, 8'h33, 1, "R10");
    // R10: store on every valid cycle in mode 0
    cfg(3'd4, 16'd0, "R2");
    bus(16'h4444, 8'h00, 0, "R10");

    // randomised mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [AW-1:0] ad;
      k = $urandom_range(0, 99);
      if (k < 4) begin
        cfg(3'd4, AW'($urandom_range(0, 1023)), "R2");
      end else if (k < 6) begin
        cfg(3'($urandom_range(0, 3)), AW'($urandom_range(16'h0FF0, 16'h2010)), "R2");
      end else begin
        case ($urandom_range(0, 5))
          0: ad = m_aa;
          1: ad = m_ba;
          2: ad = m_aa + 1'b1;
          3: ad = m_ba - 1'b1;
          default: ad = AW'($urandom_range(16'h0FF0, 16'h2010));
        endcase
        step(1'($urandom_range(0, 7) != 0), ad,
             ($urandom_range(0, 1) != 0) ? m_bd : DW'($urandom),
             1'($urandom_range(0, 1)), 1'b0, 3'd0, '0, mtag(int'(m_ctl[3:0])));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule